// File: doc/BRIEF.md
# Dual-Edge IQ Sample Bus Deframer

This block accepts the receive side of a radio transceiver's sample bus. The bus is a 12-bit word lane that carries one word on each edge of a source-synchronous receive clock, together with a frame strobe. The block captures the words on both clock edges. It uses the frame strobe to find word boundaries and rebuilds parallel I and Q words. It also passes out the receive clock as the radio-domain clock, and every output is registered on that clock.

A mode input selects one of two layouts. With the mode low (one channel), each receive-clock cycle carries an I word on the falling edge and a Q word on the rising edge. The strobe is high during the I word and low during the Q word. With the mode high (two channels), a frame lasts two receive-clock cycles and carries four words. The strobe is high for the first pair, which belongs to channel 1, and low for the second pair, which belongs to channel 0. The block only aligns on a low-to-high step of the strobe, so it drops any words that arrive before the first such step or that break the expected strobe pattern.

The transceiver cannot be stalled, so the output side is a valid-only stream. Each one-cycle pulse of `out_valid` marks a fresh result, and no ready input exists because a source clocked by the bus itself cannot accept back-pressure. The consumer must take every word on the cycle it is marked.

Top module: `iq_ddr_deframer`

## Requirements
- R1: A synchronous reset (sampled on the rising receive-clock edge) sets all four output words to zero, drops `out_valid`, and clears alignment and mode history.
- R2: In single-channel mode, a word captured on a falling edge with the strobe high, followed by a word on the next rising edge with the strobe low, is written to `ch0_i` and `ch0_q`. This happens at that rising edge, and `out_valid` is high for the following cycle. The rising edge before the pair must also have seen the strobe low.
- R3: In single-channel mode, `ch1_i` and `ch1_q` never change. They keep their last dual-channel value, or zero after reset.
- R4: In dual-channel mode, a frame is two cycles with strobe pattern high,high then low,low (falling, rising, falling, rising). The preceding rising edge must be low. The first pair goes to `ch1_i`/`ch1_q` and the second pair to `ch0_i`/`ch0_q`. All four outputs update together at the rising edge that ends the frame, with one `out_valid` pulse, so two dual-channel pulses are never adjacent.
- R5: A pair is accepted only if the strobe went from low (at a rising edge) to high (at the next falling edge). A strobe that rises at a rising edge instead gives no output until the strobe has been low at a rising edge again.
- R6: A pair whose second word is captured with the strobe high produces no output, in either mode. A strobe held high therefore yields nothing.
- R7: In dual-channel mode, a first pair that is not followed by a pair with the strobe low on both edges is discarded. Outputs hold and no pulse is produced.
- R8: On any rising edge where the mode input differs from its value at the previous rising edge, no result is produced and a half-built dual frame is dropped. Idle cycles with the strobe low after a mode change produce nothing.
- R9: When `out_valid` is low, all four output words keep their values.
- R10: `radio_clk` follows the receive clock: it is high between a rising and a falling edge and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rx | input | 1 | Source-synchronous receive clock |
| rst | input | 1 | Synchronous reset, active high |
| dual_mode | input | 1 | 0: one channel, 1: two channels |
| frame_strb | input | 1 | Frame strobe from the transceiver |
| rx_word | input | 12 | Sample word, one per clock edge |
| radio_clk | output | 1 | Radio-domain clock (the receive clock) |
| ch0_i | output | 12 | Channel 0 in-phase word |
| ch0_q | output | 12 | Channel 0 quadrature word |
| ch1_i | output | 12 | Channel 1 in-phase word |
| ch1_q | output | 12 | Channel 1 quadrature word |
| out_valid | output | 1 | One-cycle pulse per updated result |

## Verification
The interesting collision is a mode change that lands on the same rising edge that would complete a dual-channel frame. There, the commit of the staged channel-1 pair and the mode-change discard compete. The bench provokes it by sending a valid first pair and then flipping the mode on the cycle that carries the low-strobe second pair. It expects no pulse and all four words unchanged. The second overlap is single-channel back-to-back traffic, where a result is issued while the next pair's alignment step is being sampled. Here the cycle-by-cycle reference model must see one pulse on every cycle, with the words advancing each time.

// File: rtl/iqdf_pkg.sv
`timescale 1ns/1ps
package iqdf_pkg;
  typedef enum logic {
    LANE_SINGLE = 1'b0,
    LANE_DUAL   = 1'b1
  } lane_mode_e;

  typedef struct packed {
    logic on_fall;
    logic on_rise;
    logic prior_rise;
  } strb_view_t;
endpackage

// File: rtl/iqdf_ddr_capture.sv
`timescale 1ns/1ps
module iqdf_ddr_capture #(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strb_in,
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] first_word,
  output logic [WORD_W-1:0] second_word,
  output logic              strb_fall,
  output logic              strb_rise
);
  logic [WORD_W-1:0] fall_word_q;
  logic              fall_strb_q;

  // falling-edge half of the dual-edge capture
  always_ff @(negedge clk) begin
    if (rst) begin
      fall_word_q <= '0;
      fall_strb_q <= 1'b0;
    end else begin
      fall_word_q <= word_in;
      fall_strb_q <= strb_in;
    end
  end

  // rising-edge half: the live lane is registered by the consumers
  assign first_word  = fall_word_q;
  assign second_word = word_in;
  assign strb_fall   = fall_strb_q;
  assign strb_rise   = strb_in;
endmodule

// File: rtl/iqdf_aligner.sv
`timescale 1ns/1ps
module iqdf_aligner
  import iqdf_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic dual_mode,
  input  logic strb_fall,
  input  logic strb_rise,
  output logic take_single,
  output logic take_first,
  output logic take_second
);
  lane_mode_e mode_q;
  lane_mode_e mode_now;
  logic       prior_rise_q;
  logic       armed_q;
  strb_view_t view;
  logic       mode_same;
  logic       step_up;

  always_comb begin
    mode_now        = lane_mode_e'(dual_mode);
    view.on_fall    = strb_fall;
    view.on_rise    = strb_rise;
    view.prior_rise = prior_rise_q;
    mode_same       = (mode_now == mode_q);
    step_up         = view.on_fall & ~view.prior_rise;
    take_single = mode_same & (mode_now == LANE_SINGLE) & step_up & ~view.on_rise;
    take_first  = mode_same & (mode_now == LANE_DUAL) & step_up & view.on_rise;
    take_second = mode_same & (mode_now == LANE_DUAL) & armed_q
                  & ~view.on_fall & ~view.on_rise;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q       <= LANE_SINGLE;
      prior_rise_q <= 1'b0;
      armed_q      <= 1'b0;
    end else begin
      mode_q       <= mode_now;
      prior_rise_q <= strb_rise;
      armed_q      <= take_first;
    end
  end
endmodule

// File: rtl/iqdf_router.sv
`timescale 1ns/1ps
module iqdf_router #(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] first_word,
  input  logic [WORD_W-1:0] second_word,
  input  logic              take_single,
  input  logic              take_first,
  input  logic              take_second,
  output logic [WORD_W-1:0] ch0_i,
  output logic [WORD_W-1:0] ch0_q,
  output logic [WORD_W-1:0] ch1_i,
  output logic [WORD_W-1:0] ch1_q,
  output logic              out_valid
);
  localparam int PAIR_W = 2 * WORD_W;

  logic [PAIR_W-1:0] stage_q;
  logic [PAIR_W-1:0] lane0_q;
  logic [PAIR_W-1:0] lane1_q;
  logic              valid_q;
  logic              write_lane0;

  assign write_lane0 = take_single | take_second;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      lane0_q <= '0;
      lane1_q <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= write_lane0;
      if (take_first)  stage_q <= {first_word, second_word};
      if (write_lane0) lane0_q <= {first_word, second_word};
      if (take_second) lane1_q <= stage_q;
    end
  end

  assign ch0_i     = lane0_q[PAIR_W-1:WORD_W];
  assign ch0_q     = lane0_q[WORD_W-1:0];
  assign ch1_i     = lane1_q[PAIR_W-1:WORD_W];
  assign ch1_q     = lane1_q[WORD_W-1:0];
  assign out_valid = valid_q;
endmodule

// File: rtl/iq_ddr_deframer.sv
`timescale 1ns/1ps
module iq_ddr_deframer #(
  parameter int WORD_W = 12
) (
  input  logic              clk_rx,
  input  logic              rst,
  input  logic              dual_mode,
  input  logic              frame_strb,
  input  logic [WORD_W-1:0] rx_word,
  output logic              radio_clk,
  output logic [WORD_W-1:0] ch0_i,
  output logic [WORD_W-1:0] ch0_q,
  output logic [WORD_W-1:0] ch1_i,
  output logic [WORD_W-1:0] ch1_q,
  output logic              out_valid
);
  logic [WORD_W-1:0] first_word;
  logic [WORD_W-1:0] second_word;
  logic              strb_fall;
  logic              strb_rise;
  logic              take_single;
  logic              take_first;
  logic              take_second;

  assign radio_clk = clk_rx;

  iqdf_ddr_capture #(.WORD_W(WORD_W)) u_capture (
    .clk         (clk_rx),
    .rst         (rst),
    .strb_in     (frame_strb),
    .word_in     (rx_word),
    .first_word  (first_word),
    .second_word (second_word),
    .strb_fall   (strb_fall),
    .strb_rise   (strb_rise)
  );

  iqdf_aligner u_align (
    .clk         (clk_rx),
    .rst         (rst),
    .dual_mode   (dual_mode),
    .strb_fall   (strb_fall),
    .strb_rise   (strb_rise),
    .take_single (take_single),
    .take_first  (take_first),
    .take_second (take_second)
  );

  iqdf_router #(.WORD_W(WORD_W)) u_route (
    .clk         (clk_rx),
    .rst         (rst),
    .first_word  (first_word),
    .second_word (second_word),
    .take_single (take_single),
    .take_first  (take_first),
    .take_second (take_second),
    .ch0_i       (ch0_i),
    .ch0_q       (ch0_q),
    .ch1_i       (ch1_i),
    .ch1_q       (ch1_q),
    .out_valid   (out_valid)
  );
endmodule

// File: rtl/iqdf_checks.sv
`timescale 1ns/1ps
module iqdf_checks #(
  parameter int WORD_W = 12
) (
  input logic              clk_rx,
  input logic              rst,
  input logic              dual_mode,
  input logic              frame_strb,
  input logic [WORD_W-1:0] ch0_i,
  input logic [WORD_W-1:0] ch0_q,
  input logic [WORD_W-1:0] ch1_i,
  input logic [WORD_W-1:0] ch1_q,
  input logic              out_valid
);
  logic [1:0] age;
  logic       rst_q;

  always_ff @(posedge clk_rx) begin
    rst_q <= rst;
    if (rst) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R1
  always @(posedge clk_rx) begin
    if (rst_q) begin
      reset_clear_chk: assert (!out_valid && ch0_i == '0 && ch0_q == '0
                               && ch1_i == '0 && ch1_q == '0);
    end
  end

  // R3
  ch1_hold_chk: assert property (@(posedge clk_rx) disable iff (rst)
    (age != 2'd0 && !$past(dual_mode)) |-> $stable({ch1_i, ch1_q}));

  // R9
  quiet_stable_chk: assert property (@(posedge clk_rx) disable iff (rst)
    (age != 2'd0 && !out_valid) |-> $stable({ch0_i, ch0_q, ch1_i, ch1_q}));

  // R4
  dual_spacing_chk: assert property (@(posedge clk_rx) disable iff (rst)
    (age != 2'd0 && out_valid && $past(dual_mode)) |=> !out_valid);

  // R6
  second_low_chk: assert property (@(posedge clk_rx) disable iff (rst)
    (age != 2'd0 && out_valid) |-> !$past(frame_strb));

  // R8
  mode_flip_chk: assert property (@(posedge clk_rx) disable iff (rst)
    (age >= 2'd2 && $past(dual_mode) != $past(dual_mode, 2)) |-> !out_valid);
endmodule

bind iq_ddr_deframer iqdf_checks #(.WORD_W(WORD_W)) u_checks (
  .clk_rx     (clk_rx),
  .rst        (rst),
  .dual_mode  (dual_mode),
  .frame_strb (frame_strb),
  .ch0_i      (ch0_i),
  .ch0_q      (ch0_q),
  .ch1_i      (ch1_i),
  .ch1_q      (ch1_q),
  .out_valid  (out_valid)
);

// File: tb/iq_ddr_deframer_test.sv
`timescale 1ns/1ps
module iq_ddr_deframer_test;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         dual = 1'b0;
  logic         strb = 1'b0;
  logic [W-1:0] bus = '0;
  logic         radio_clk;
  logic [W-1:0] ch0_i, ch0_q, ch1_i, ch1_q;
  logic         out_valid;

  int checks = 0;
  int fails = 0;
  int vcnt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  iq_ddr_deframer #(.WORD_W(W)) uut (
    .clk_rx(clk), .rst(rst), .dual_mode(dual), .frame_strb(strb), .rx_word(bus),
    .radio_clk(radio_clk), .ch0_i(ch0_i), .ch0_q(ch0_q), .ch1_i(ch1_i),
    .ch1_q(ch1_q), .out_valid(out_valid)
  );

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: history of (strobe, word) per edge and mode per rising edge
  logic [W:0]   hist[$];
  logic         mh[$];
  logic [W-1:0] e0i = '0, e0q = '0, e1i = '0, e1q = '0;
  logic         ev = 1'b0;

  function automatic logic [W:0] wb(int k);
    if (hist.size() >= k) return hist[hist.size() - k];
    return '0;
  endfunction

  function automatic logic mb(int k);
    if (mh.size() >= k) return mh[mh.size() - k];
    return 1'b0;
  endfunction

  always @(negedge clk) hist.push_back({strb, bus});

  always @(posedge clk) begin
    if (rst) begin
      hist.delete(); mh.delete();
      e0i = '0; e0q = '0; e1i = '0; e1q = '0; ev = 1'b0;
    end else begin
      hist.push_back({strb, bus});
      mh.push_back(dual);
      while (hist.size() > 8) void'(hist.pop_front());
      while (mh.size() > 4) void'(mh.pop_front());
      ev = 1'b0;
      if (!mb(1) && !mb(2) && wb(2)[W] && !wb(3)[W] && !wb(1)[W]) begin
        e0i = wb(2)[W-1:0]; e0q = wb(1)[W-1:0]; ev = 1'b1;
      end else if (mb(1) && mb(2) && mb(3) && wb(4)[W] && wb(3)[W] && !wb(5)[W]
                   && !wb(2)[W] && !wb(1)[W]) begin
        e1i = wb(4)[W-1:0]; e1q = wb(3)[W-1:0];
        e0i = wb(2)[W-1:0]; e0q = wb(1)[W-1:0]; ev = 1'b1;
      end
    end
  end

  // compare every cycle, away from both edges
  always @(posedge clk) begin
    #1.5;
    if (!done) begin
      chk(out_valid == ev, "R9 valid", out_valid, ev);
      chk(ch0_i == e0i, dual ? "R4 ch0_i" : "R2 ch0_i", ch0_i, e0i);
      chk(ch0_q == e0q, dual ? "R4 ch0_q" : "R2 ch0_q", ch0_q, e0q);
      chk(ch1_i == e1i, dual ? "R4 ch1_i" : "R3 ch1_i", ch1_i, e1i);
      chk(ch1_q == e1q, dual ? "R4 ch1_q" : "R3 ch1_q", ch1_q, e1q);
      if (out_valid) vcnt++;
    end
  end

  task automatic cyc(logic m, logic [W-1:0] fw, logic fs, logic [W-1:0] rw, logic rs);
    @(posedge clk); #1;
    dual = m; bus = fw; strb = fs;
    @(negedge clk); #1;
    bus = rw; strb = rs;
  endtask

  task automatic idle(logic m, int n);
    for (int k = 0; k < n; k++) cyc(m, W'(12'h5A0 + k), 1'b0, W'(12'h0A5 + k), 1'b0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    chk({ch0_i, ch0_q, ch1_i, ch1_q, out_valid} == '0, "R1 reset state",
        {ch0_i, ch0_q, ch1_i, ch1_q, out_valid}, 0);
    @(posedge clk); #0.5;
    chk(radio_clk == 1'b1, "R10 high phase", radio_clk, 1);
    @(negedge clk); #0.5;
    chk(radio_clk == 1'b0, "R10 low phase", radio_clk, 0);

    idle(1'b0, 4);
    // R2: back-to-back single-channel pairs
    vcnt = 0;
    for (int n = 0; n < 5; n++) cyc(1'b0, W'(12'hA00 + n), 1'b1, W'(12'hB00 + n), 1'b0);
    idle(1'b0, 2);
    chk(vcnt == 5, "R2 pulse count", vcnt, 5);
    chk(ch0_i == 12'hA04 && ch0_q == 12'hB04, "R2 last pair", {ch0_i, ch0_q}, 24'hA04B04);
    chk(ch1_i == '0 && ch1_q == '0, "R3 ch1 zero in single", {ch1_i, ch1_q}, 0);

    // R6: strobe held high
    vcnt = 0;
    for (int n = 0; n < 3; n++) cyc(1'b0, W'(12'h111 + n), 1'b1, W'(12'h222 + n), 1'b1);
    idle(1'b0, 2);
    chk(vcnt == 0, "R6 stuck-high strobe", vcnt, 0);

    // R5: strobe steps up on a rising edge
    vcnt = 0;
    cyc(1'b0, 12'h333, 1'b0, 12'h444, 1'b1);
    cyc(1'b0, 12'h555, 1'b1, 12'h666, 1'b0);
    idle(1'b0, 2);
    chk(vcnt == 0, "R5 misaligned step", vcnt, 0);
    chk(ch0_i == 12'hA04, "R5 outputs held", ch0_i, 12'hA04);

    // switch to dual, R8 idle tolerance
    vcnt = 0;
    idle(1'b1, 4);
    chk(vcnt == 0, "R8 idle after mode change", vcnt, 0);

    // R4: four dual frames
    vcnt = 0;
    for (int n = 0; n < 4; n++) begin
      cyc(1'b1, W'(12'hC00 + n), 1'b1, W'(12'hD00 + n), 1'b1);
      cyc(1'b1, W'(12'hE00 + n), 1'b0, W'(12'hF00 + n), 1'b0);
    end
    idle(1'b1, 2);
    chk(vcnt == 4, "R4 frame count", vcnt, 4);
    chk({ch1_i, ch1_q} == 24'hC03D03, "R4 first pair to ch1", {ch1_i, ch1_q}, 24'hC03D03);
    chk({ch0_i, ch0_q} == 24'hE03F03, "R4 second pair to ch0", {ch0_i, ch0_q}, 24'hE03F03);

    // R7: first pair followed by a high-strobe pair
    vcnt = 0;
    cyc(1'b1, 12'h701, 1'b1, 12'h702, 1'b1);
    cyc(1'b1, 12'h703, 1'b1, 12'h704, 1'b1);
    idle(1'b1, 3);
    chk(vcnt == 0, "R7 broken frame", vcnt, 0);
    chk(ch1_i == 12'hC03, "R7 ch1 held", ch1_i, 12'hC03);

    // R8: mode flips on the completing cycle
    vcnt = 0;
    cyc(1'b1, 12'h801, 1'b1, 12'h802, 1'b1);
    cyc(1'b0, 12'h803, 1'b0, 12'h804, 1'b0);
    idle(1'b0, 3);
    chk(vcnt == 0, "R8 flip discards frame", vcnt, 0);
    chk({ch0_i, ch1_i} == 24'hE03C03, "R8 outputs held", {ch0_i, ch1_i}, 24'hE03C03);

    // R3: single-channel pair leaves ch1 as it was
    cyc(1'b0, 12'h901, 1'b1, 12'h902, 1'b0);
    idle(1'b0, 2);
    chk({ch0_i, ch0_q} == 24'h901902, "R2 after dual", {ch0_i, ch0_q}, 24'h901902);
    chk({ch1_i, ch1_q} == 24'hC03D03, "R3 ch1 hold", {ch1_i, ch1_q}, 24'hC03D03);

    // R1: reset mid-run
    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk); #1.7;
    chk({ch0_i, ch0_q, ch1_i, ch1_q, out_valid} == '0, "R1 mid-run reset",
        {ch0_i, ch0_q, ch1_i, ch1_q, out_valid}, 0);
    @(posedge clk); #1 rst = 1'b0;
    idle(1'b0, 3);
    finish_run();
  end
endmodule